// File: doc/BRIEF.md
# Flash Request Chunking Engine

This block sits between a software-facing request port and a flash command sequencer. A caller gives it one large request: a read, a write or an erase, with a start byte address and a byte length. The engine turns that request into a series of small sequencer commands. It sends one command at a time and waits for each to finish, then it reports one final status for the whole request.

Read and write chunks are sized so that each fits the sequencer's data buffer and stays inside one flash page. Erase requests must be sector aligned. For each erase step the engine uses the larger block erase when the address and the remaining length allow it, and the small sector erase when they do not. The first failed or silent command ends the request.

Top module: `flash_chunk_eng`

## Requirements
- R1: Each read (op 0) or write (op 1) command carries a nonzero length equal to the smaller of the remaining length and BUF_BYTES (default 64), unless R2 limits it further. The command kind is 0 for read and 1 for write.
- R2: When the current address is not a multiple of the 256-byte page, the read/write chunk is also capped at the bytes left before the next page boundary, so no chunk crosses a page.
- R3: The first command starts at the request address. Each later command starts at the previous command's address plus its length. A successful request ends when the lengths sum to the request length.
- R4: An erase (op 2) whose address or length has any of bits 11:0 set ends with status 2 (argument error), and no command is issued. An op code of 3 ends the same way.
- R5: Each erase step issues kind 3 (64 KiB, length 65536) when address bits 15:0 are zero and at least 65536 bytes remain. Otherwise it issues kind 2 (4 KiB, length 4096).
- R6: A response with rsp_err high ends the request with status 1 (hardware error), and no further command is issued.
- R7: If no response arrives within TIMEOUT_CYC cycles after a command is accepted, the request ends with status 3 (timeout).
- R8: A request of length zero ends with status 0 and issues no command.
- R9: At most one command is outstanding. cmd_valid stays low from the command handshake until its response. A fully successful request ends with status 0, given by a one-cycle done_valid pulse.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_kind, cmd_addr and cmd_len hold their values.
- R11: req_ready is high only while the engine is idle. A rsp_valid pulse that arrives while no command is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken on handshake |
| req_op | input | 2 | 0 read, 1 write, 2 erase |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| cmd_valid | output | 1 | Command offered to the sequencer |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_kind | output | 2 | 0 read, 1 write, 2 erase 4 KiB, 3 erase 64 KiB |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_len | output | LEN_W | Command byte count (erase size for erases) |
| rsp_valid | input | 1 | Command completion |
| rsp_err | input | 1 | Completion carries an error |
| done_valid | output | 1 | One-cycle pulse when the request ends |
| done_status | output | 2 | 0 ok, 1 hardware error, 2 argument error, 3 timeout |

## Verification
The hardest case to reach is a mixed erase: a single request that needs small erases to reach a 64 KiB boundary, then large erases, then small erases again for a short tail. The bench reaches it with an erase that starts 4 KiB below a 64 KiB boundary and ends 4 KiB past one. It also reaches the timeout by having its responder accept a command and then stay silent. The bench overrides the timeout limit with a short value, so the silent case ends quickly.

// File: rtl/fce_pkg.sv
// Shared encodings for the flash request chunking engine.
package fce_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_ER4K  = 2'd2,
        K_ER64K = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_HWERR   = 2'd1,
        ST_ARGERR  = 2'd2,
        ST_TIMEOUT = 2'd3
    } status_e;
endpackage

// File: rtl/fce_rw_sizer.sv
// Read/write chunk sizer: returns the smaller of the remaining length and the
// buffer size. When the page offset is nonzero, it also caps the result at the
// bytes left in the page. Assumes rem is nonzero whenever the result is used.
module fce_rw_sizer #(
    parameter int LEN_W      = 32,
    parameter int BUF_BYTES  = 64,
    parameter int PAGE_BYTES = 256,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic [PG_W-1:0]  page_off,
    input  logic [LEN_W-1:0] rem,
    output logic [LEN_W-1:0] chunk
);
    logic [LEN_W-1:0] page_left;

    // Chunk size: the smallest of the remaining length, the buffer and the page remainder.
    always_comb begin
        page_left = LEN_W'(PAGE_BYTES) - LEN_W'(page_off);
        chunk     = (rem < LEN_W'(BUF_BYTES)) ? rem : LEN_W'(BUF_BYTES);
        if (page_off != '0 && page_left < chunk)
            chunk = page_left;
    end
endmodule

// File: rtl/fce_erase_pick.sv
// Erase granularity picker: chooses the big erase when the address is aligned
// to the big erase size and enough length remains. Otherwise it chooses the
// small erase.
module fce_erase_pick #(
    parameter int LEN_W     = 32,
    parameter int SMALL_LOG2 = 12,
    parameter int BIG_LOG2   = 16
) (
    input  logic [BIG_LOG2-1:0] addr_low,
    input  logic [LEN_W-1:0]    rem,
    output logic                big,
    output logic [LEN_W-1:0]    size
);
    // Granularity choice made fresh for each erase step.
    always_comb begin
        big  = (addr_low == '0) && (rem >= (LEN_W'(1) << BIG_LOG2));
        size = big ? (LEN_W'(1) << BIG_LOG2) : (LEN_W'(1) << SMALL_LOG2);
    end
endmodule

// File: rtl/fce_timer.sv
// Response timer: counts while run is high and clears when run is low.
// expired pulses on the LIMIT-th cycle of a run. Assumes LIMIT >= 1.
module fce_timer #(
    parameter int LIMIT = 1000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    // Cycle counter for the outstanding command.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_chunk_eng.sv
// Flash request chunking engine. It takes one read, write or erase request and
// issues sequencer commands one at a time. It waits for each response and then
// reports one status. Assumes the sequencer answers each accepted command at
// most once.
module flash_chunk_eng
    import fce_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 32,
    parameter int BUF_BYTES   = 64,
    parameter int PAGE_BYTES  = 256,
    parameter int SMALL_LOG2  = 12,
    parameter int BIG_LOG2    = 16,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    output logic              done_valid,
    output logic [1:0]        done_status
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

    state_e            state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  step;
    logic              is_erase;
    logic              is_write;
    status_e           status;

    logic [LEN_W-1:0]  rw_chunk;
    logic [LEN_W-1:0]  er_size;
    logic              er_big;
    logic              tmo;
    logic              misaligned;

    fce_rw_sizer #(
        .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .PAGE_BYTES(PAGE_BYTES)
    ) u_sizer (
        .page_off(cur_addr[PG_W-1:0]),
        .rem     (rem),
        .chunk   (rw_chunk)
    );

    fce_erase_pick #(
        .LEN_W(LEN_W), .SMALL_LOG2(SMALL_LOG2), .BIG_LOG2(BIG_LOG2)
    ) u_pick (
        .addr_low(cur_addr[BIG_LOG2-1:0]),
        .rem     (rem),
        .big     (er_big),
        .size    (er_size)
    );

    fce_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == S_WAIT),
        .expired(tmo)
    );

    // Sector alignment test applied to erase requests.
    assign misaligned = (req_addr[SMALL_LOG2-1:0] != '0) ||
                        (req_len[SMALL_LOG2-1:0] != '0);

    // Command fields are driven from the held request state.
    always_comb begin
        cmd_valid = (state == S_ISSUE);
        cmd_addr  = cur_addr;
        if (is_erase) begin
            cmd_kind = er_big ? K_ER64K : K_ER4K;
            cmd_len  = er_size;
        end else begin
            cmd_kind = is_write ? K_WRITE : K_READ;
            cmd_len  = rw_chunk;
        end
    end

    assign req_ready   = (state == S_IDLE);
    assign done_valid  = (state == S_DONE);
    assign done_status = status;

    // Sequencing state machine: accept, issue, wait, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            step     <= '0;
            is_erase <= 1'b0;
            is_write <= 1'b0;
            status   <= ST_OK;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    cur_addr <= req_addr;
                    rem      <= req_len;
                    is_erase <= (req_op == OP_ERASE);
                    is_write <= (req_op == OP_WRITE);
                    status   <= ST_OK;
                    if (req_op == OP_BAD || (req_op == OP_ERASE && misaligned)) begin
                        status <= ST_ARGERR;
                        state  <= S_DONE;
                    end else if (req_len == '0) begin
                        state <= S_DONE;
                    end else begin
                        state <= S_ISSUE;
                    end
                end
                S_ISSUE: if (cmd_ready) begin
                    step  <= cmd_len;
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            status <= ST_HWERR;
                            state  <= S_DONE;
                        end else begin
                            cur_addr <= cur_addr + ADDR_W'(step);
                            rem      <= rem - step;
                            state    <= (rem == step) ? S_DONE : S_ISSUE;
                        end
                    end else if (tmo) begin
                        status <= ST_TIMEOUT;
                        state  <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_chunk_chk.sv
// Checker for flash_chunk_eng. It watches the ports and tracks whether a
// command is outstanding and whether any command was sent for the current
// request.
module flash_chunk_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int BUF_BYTES  = 64,
    parameter int PAGE_BYTES = 256,
    parameter int BIG_LOG2   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              rsp_valid,
    input logic              done_valid,
    input logic [1:0]        done_status
);
    logic outstanding;
    logic sent_any;

    // Tracks one accepted command until its response or the end of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= 1'b0;
        else if (cmd_valid && cmd_ready) outstanding <= 1'b1;
        else if (rsp_valid || done_valid) outstanding <= 1'b0;
    end

    // Tracks whether the current request issued any command.
    always_ff @(posedge clk) begin
        if (!rst_n) sent_any <= 1'b0;
        else if (req_valid && req_ready) sent_any <= 1'b0;
        else if (cmd_valid && cmd_ready) sent_any <= 1'b1;
    end

    a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind[1] == 1'b0) |->
            (cmd_len != '0 && cmd_len <= LEN_W'(BUF_BYTES)));

    a_r2_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind[1] == 1'b0) |->
            ((LEN_W'(cmd_addr % ADDR_W'(PAGE_BYTES)) + cmd_len) <= LEN_W'(PAGE_BYTES)));

    a_r5_big_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd3) |-> (cmd_addr[BIG_LOG2-1:0] == '0));

    a_r4_arg_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == 2'd2) |-> !sent_any);

    a_r9_single_out: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !cmd_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_len)));

    a_r11_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !done_valid));
endmodule

bind flash_chunk_eng flash_chunk_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .BIG_LOG2(BIG_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .rsp_valid(rsp_valid),
    .done_valid(done_valid), .done_status(done_status)
);

// File: tb/sim_flash_chunk_eng.sv
`timescale 1ns/1ps
module sim_flash_chunk_eng;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 32;
    localparam int BUFB   = 64;
    localparam int PAGEB  = 256;
    localparam int TMO    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [1:0]        cmd_kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic              rsp_valid = 1'b0;
    logic              rsp_err = 1'b0;
    logic              done_valid;
    logic [1:0]        done_status;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_chunk_eng #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .done_valid(done_valid), .done_status(done_status)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Runs one request against a responder; err_idx/silent_idx pick a command to fail (-1: none).
    task automatic run_req(input string req, input logic [1:0] op, input longint addr,
                           input longint len, input int err_idx, input int silent_idx,
                           input int exp_st, input int exp_cmds);
        longint e_addr = addr;
        longint e_rem  = len;
        int n = 0;
        int guard = 0;
        longint e_len;
        int e_kind;
        @(negedge clk);
        check(req_ready == 1'b1, {req, " idle"}, req_ready, 1);
        req_valid = 1'b1; req_op = op; req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (done_valid) break;
            if (guard++ > 5000) break;
            if (cmd_valid) begin
                if (op == 2'd2) begin
                    if (e_addr % 65536 == 0 && e_rem >= 65536) begin e_kind = 3; e_len = 65536; end
                    else begin e_kind = 2; e_len = 4096; end
                end else begin
                    e_kind = op;
                    e_len = (e_rem < BUFB) ? e_rem : BUFB;
                    if (e_addr % PAGEB != 0 && (PAGEB - e_addr % PAGEB) < e_len)
                        e_len = PAGEB - e_addr % PAGEB;
                end
                check(cmd_kind == 2'(e_kind), {req, " kind"}, cmd_kind, e_kind);
                check(cmd_addr == ADDR_W'(e_addr), {req, " R3 addr"}, cmd_addr, e_addr);
                check(cmd_len == LEN_W'(e_len), {req, " len"}, cmd_len, e_len);
                // R10: hold one extra cycle without ready
                @(negedge clk);
                check(cmd_valid && cmd_addr == ADDR_W'(e_addr) && cmd_len == LEN_W'(e_len),
                      {req, " R10 hold"}, cmd_len, e_len);
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                @(negedge clk);
                check(cmd_valid == 1'b0, {req, " R9 one outstanding"}, cmd_valid, 0);
                if (n == silent_idx) begin
                    n++;
                    silent_idx = -2;
                    continue;
                end
                rsp_valid = 1'b1; rsp_err = (n == err_idx);
                @(negedge clk);
                rsp_valid = 1'b0; rsp_err = 1'b0;
                e_addr += e_len; e_rem -= e_len; n++;
                continue;
            end
            @(negedge clk);
        end
        check(done_valid == 1'b1, {req, " done seen"}, done_valid, 1);
        check(done_status == 2'(exp_st), {req, " status"}, done_status, exp_st);
        check(n == exp_cmds, {req, " command count"}, n, exp_cmds);
        @(negedge clk);
        check(done_valid == 1'b0, {req, " done one cycle"}, done_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0 && done_valid == 1'b0,
              "reset state", {req_ready, cmd_valid, done_valid}, 3'b100);
    endtask

    task automatic t_stray_rsp();
        // R11: a response while idle must not produce a completion or a command
        @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(done_valid == 1'b0 && cmd_valid == 1'b0 && req_ready == 1'b1,
              "R11 stray response", {done_valid, cmd_valid, req_ready}, 3'b001);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_req("R1 read aligned",     2'd0, 'h1000, 200, -1, -1, 0, 4);
        run_req("R2 write unaligned",  2'd1, 'h10F0, 100, -1, -1, 0, 3);
        run_req("R2 read page span",   2'd0, 'h0030, 300, -1, -1, 0, 6);
        run_req("R5 mixed erase",      2'd2, 'hF000, 'h22000, -1, -1, 0, 4);
        run_req("R5 small erase only", 2'd2, 'h11000, 'h10000, -1, -1, 0, 16);
        run_req("R4 erase bad addr",   2'd2, 'h0800, 'h1000, -1, -1, 2, 0);
        run_req("R4 erase bad len",    2'd2, 'h1000, 'h1800, -1, -1, 2, 0);
        run_req("R4 bad op",           2'd3, 'h0000, 16, -1, -1, 2, 0);
        run_req("R8 zero length",      2'd0, 'h2000, 0, -1, -1, 0, 0);
        run_req("R6 hw error",         2'd1, 'h0000, 256, 1, -1, 1, 2);
        run_req("R7 timeout",          2'd0, 'h0040, 128, -1, 0, 3, 1);
        t_stray_rsp();
        run_req("R9 after stray",      2'd0, 'h00FF, 2, -1, -1, 0, 2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule